// File: doc/BRIEF.md
# Variable-Capacity Hash Bucket Lookup

This block is a hashed key store. A 128-bit key is folded into a 16-bit checksum, and the low bits of that checksum select a bucket descriptor. The descriptor points at a bucket of 1, 4, 8 or 16 key slots. Every bucket lives inside a 16-slot group of on-chip storage, and each key slot has a 128-bit data slot beside it. A search compares every occupied slot of the selected bucket against the key at once and returns the data of the slot that matches.

An insert that lands on a full bucket, or on an index that has no bucket yet, takes a bucket from a per-size free pool. Each pool is a FIFO of bucket pointers that is loaded at reset from a static split of the groups. The engine tries the smallest usable size first and moves up one size at a time when a pool is empty. On promotion the resident keys and their data are copied to the new bucket together with the new key, and the old bucket goes back to its own pool.

The engine handles one command at a time. It takes a request while `req_ready_o` is high and answers with a single-cycle response pulse.

Top module: `bucket_lookup`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0, no index holds a bucket, and every search returns status 1 (miss).
- R2: The table index is the low TBL_AW bits of the ones'-complement sum, with end-around carry, of the eight 16-bit words of the key.
- R3: The response pulse comes exactly 5 rising edges after the edge that accepts a request and lasts one cycle. `req_ready_o` is 0 from the accept edge until the response edge, and it is 1 while the response is shown.
- R4: A search for a stored key returns status 0 (ok) with the data stored for that key.
- R5: A search for a key that is not stored returns status 1 (miss) with data 0. Every non-ok response carries data 0.
- R6: An insert to an index without a bucket takes a 1-key bucket and returns status 0.
- R7: An insert that finds its bucket full moves to the next larger bucket (capacities 1, 4, 8, 16; type codes 0 to 3). The old keys and their data stay searchable.
- R8: When the pool for the wanted size is empty, the next larger size with a free bucket is used instead.
- R9: An insert for which no free bucket of sufficient size exists returns status 2 (overflow) and leaves all stored keys and data unchanged.
- R10: An insert of a key that is already stored returns status 3 (duplicate) and does not change its data.
- R11: A bucket released by a promotion goes back to its pool and can be handed out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request taken at the next edge |
| req_insert_i | input | 1 | 1 = insert, 0 = search |
| req_key_i | input | 128 | Key |
| req_data_i | input | 128 | Data to store on insert |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_status_o | output | 2 | 0 ok, 1 miss, 2 overflow, 3 duplicate |
| rsp_data_o | output | 128 | Data found by a search, otherwise 0 |

## Verification
Each command is accepted on one edge, passes through four hash stages, and its response is registered on the fifth edge after acceptance. The bench counts falling edges from the accept edge: `req_ready_o` must be low at the first four, and status and data are read at the fifth, where the pulse must appear. Expected status and data come from a bench model of per-index bucket size, key count and per-size free counts. That model makes promotion, cascading and overflow positions visible, because a wrong choice of pool moves the first overflow to a different point in the command sequence.

// File: rtl/kvb_pkg.sv
package kvb_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_MISS = 2'd1,
    ST_FULL = 2'd2,
    ST_DUP  = 2'd3
  } status_e;

  // bucket pointer: {group[15:0], bucket_no[3:0]}
  typedef struct packed {
    logic        vld;
    logic [1:0]  cls;
    logic [19:0] ptr;
    logic [4:0]  cnt;
  } desc_t;

  function automatic logic [15:0] oc_add(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [4:0] cls_cap(logic [1:0] c);
    case (c)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // bits of bucket_no that are significant for a class
  function automatic logic [3:0] bn_mask(logic [1:0] c);
    case (c)
      2'd0:    return 4'hF;
      2'd1:    return 4'hC;
      2'd2:    return 4'h8;
      default: return 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/kvb_hash.sv
module kvb_hash
  import kvb_pkg::*;
#(
  parameter int KEY_W  = 128,
  parameter int DATA_W = 128,
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic              in_ins_i,
  input  logic [KEY_W-1:0]  in_key_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_vld_o,
  output logic              out_ins_o,
  output logic [KEY_W-1:0]  out_key_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [15:0]       out_hash_o
);
  localparam int WPS = KEY_W / 16 / STAGES;

  logic [STAGES-1:0] vld_in, vld_q, ins_in, ins_q;
  logic [KEY_W-1:0]  key_in [STAGES];
  logic [KEY_W-1:0]  key_q  [STAGES];
  logic [DATA_W-1:0] dat_in [STAGES];
  logic [DATA_W-1:0] dat_q  [STAGES];
  logic [15:0]       acc_in [STAGES];
  logic [15:0]       acc_d  [STAGES];
  logic [15:0]       acc_q  [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign vld_in[s] = in_vld_i;
      assign ins_in[s] = in_ins_i;
      assign key_in[s] = in_key_i;
      assign dat_in[s] = in_data_i;
      assign acc_in[s] = '0;
    end else begin : g_body
      assign vld_in[s] = vld_q[s-1];
      assign ins_in[s] = ins_q[s-1];
      assign key_in[s] = key_q[s-1];
      assign dat_in[s] = dat_q[s-1];
      assign acc_in[s] = acc_q[s-1];
    end

    always_comb begin
      acc_d[s] = acc_in[s];
      for (int w = 0; w < WPS; w++)
        acc_d[s] = oc_add(acc_d[s], key_in[s][(s*WPS+w)*16 +: 16]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        ins_q[s] <= 1'b0;
        key_q[s] <= '0;
        dat_q[s] <= '0;
        acc_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_in[s];
        ins_q[s] <= ins_in[s];
        key_q[s] <= key_in[s];
        dat_q[s] <= dat_in[s];
        acc_q[s] <= acc_d[s];
      end
    end
  end

  assign out_vld_o  = vld_q[STAGES-1];
  assign out_ins_o  = ins_q[STAGES-1];
  assign out_key_o  = key_q[STAGES-1];
  assign out_data_o = dat_q[STAGES-1];
  assign out_hash_o = acc_q[STAGES-1];
endmodule

// File: rtl/kvb_free_pool.sv
module kvb_free_pool #(
  parameter int DEPTH    = 16,
  parameter int GRP_BASE = 0,
  parameter int BPG      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pop_i,
  input  logic        push_i,
  input  logic [19:0] push_ptr_i,
  output logic        empty_o,
  output logic [19:0] head_o
);
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int STRIDE = 16 / BPG;

  logic [19:0]   mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [AW:0]   cnt_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++)
        mem_q[k] <= {16'(GRP_BASE + k / BPG), 4'((k % BPG) * STRIDE)};
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= (AW+1)'(DEPTH);
    end else begin
      if (pop_i) rd_q <= nxt(rd_q);
      if (push_i) begin
        mem_q[wr_q] <= push_ptr_i;
        wr_q        <= nxt(wr_q);
      end
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
endmodule

// File: rtl/kvb_bucket_mem.sv
module kvb_bucket_mem #(
  parameter int SLOTS   = 64,
  parameter int SLOT_AW = 6,
  parameter int KEY_W   = 128,
  parameter int DATA_W  = 128,
  parameter int BKT_MAX = 16
) (
  input  logic               clk_i,
  input  logic [SLOT_AW-1:0] cmp_base_i,
  input  logic [4:0]         cmp_cnt_i,
  input  logic [KEY_W-1:0]   cmp_key_i,
  output logic               hit_o,
  output logic [DATA_W-1:0]  hit_data_o,
  input  logic               wr_en_i,
  input  logic               mv_en_i,
  input  logic [SLOT_AW-1:0] src_base_i,
  input  logic [SLOT_AW-1:0] dst_base_i,
  input  logic [4:0]         wr_pos_i,
  input  logic [KEY_W-1:0]   wr_key_i,
  input  logic [DATA_W-1:0]  wr_data_i
);
  logic [KEY_W-1:0]   key_q [SLOTS];
  logic [DATA_W-1:0]  dat_q [SLOTS];
  logic [SLOT_AW-1:0] hit_addr;

  // whole-bucket compare; slots past the key count are masked off
  always_comb begin
    hit_o    = 1'b0;
    hit_addr = '0;
    for (int j = BKT_MAX-1; j >= 0; j--) begin
      if (5'(j) < cmp_cnt_i &&
          key_q[cmp_base_i + SLOT_AW'(j)] == cmp_key_i) begin
        hit_o    = 1'b1;
        hit_addr = cmp_base_i + SLOT_AW'(j);
      end
    end
  end

  assign hit_data_o = dat_q[hit_addr];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      if (mv_en_i) begin
        for (int j = 0; j < BKT_MAX; j++) begin
          if (5'(j) < wr_pos_i) begin
            key_q[dst_base_i + SLOT_AW'(j)] <= key_q[src_base_i + SLOT_AW'(j)];
            dat_q[dst_base_i + SLOT_AW'(j)] <= dat_q[src_base_i + SLOT_AW'(j)];
          end
        end
      end
      key_q[dst_base_i + SLOT_AW'(wr_pos_i)] <= wr_key_i;
      dat_q[dst_base_i + SLOT_AW'(wr_pos_i)] <= wr_data_i;
    end
  end
endmodule

// File: rtl/bucket_lookup.sv
module bucket_lookup
  import kvb_pkg::*;
#(
  parameter int TBL_AW = 6,
  parameter int N_G1   = 1,
  parameter int N_G4   = 1,
  parameter int N_G8   = 1,
  parameter int N_G16  = 1,
  parameter int KEY_W  = 128,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_insert_i,
  input  logic [KEY_W-1:0]  req_key_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int N_GRP   = N_G1 + N_G4 + N_G8 + N_G16;
  localparam int SLOTS   = N_GRP * 16;
  localparam int SLOT_AW = $clog2(SLOTS);
  localparam int TBL_N   = 1 << TBL_AW;

  function automatic logic [SLOT_AW-1:0] slot_of(logic [19:0] p, logic [1:0] c);
    return SLOT_AW'({p[19:4], 4'b0000}) | SLOT_AW'(p[3:0] & bn_mask(c));
  endfunction

  logic busy_q, accept;
  logic h_vld, h_ins;
  logic [KEY_W-1:0]  h_key;
  logic [DATA_W-1:0] h_data;
  logic [15:0]       h_hash;
  logic              unused_hash;

  assign req_ready_o = !busy_q;
  assign accept      = req_valid_i && !busy_q;

  kvb_hash #(.KEY_W(KEY_W), .DATA_W(DATA_W), .STAGES(4)) i_hash (
    .clk_i, .rst_ni,
    .in_vld_i(accept), .in_ins_i(req_insert_i),
    .in_key_i(req_key_i), .in_data_i(req_data_i),
    .out_vld_o(h_vld), .out_ins_o(h_ins),
    .out_key_o(h_key), .out_data_o(h_data), .out_hash_o(h_hash)
  );
  assign unused_hash = ^h_hash;

  // descriptor table
  desc_t              desc_q [TBL_N];
  logic [TBL_AW-1:0]  idx;
  desc_t              cur, nxt_desc;
  logic [4:0]         cur_cnt, cur_cap;
  logic [SLOT_AW-1:0] cur_base, new_base;

  assign idx      = h_hash[TBL_AW-1:0];
  assign cur      = desc_q[idx];
  assign cur_cnt  = cur.vld ? cur.cnt : 5'd0;
  assign cur_cap  = cls_cap(cur.cls);
  assign cur_base = slot_of(cur.ptr, cur.cls);

  // free pools, one per class
  logic [3:0]  pool_empty, pool_pop, pool_push;
  logic [19:0] pool_head [4];
  logic [19:0] push_ptr;

  for (genvar c = 0; c < 4; c++) begin : g_pool
    localparam int NG  = (c == 0) ? N_G1 : (c == 1) ? N_G4 : (c == 2) ? N_G8 : N_G16;
    localparam int GB  = (c == 0) ? 0 : (c == 1) ? N_G1 :
                         (c == 2) ? N_G1 + N_G4 : N_G1 + N_G4 + N_G8;
    localparam int BPG = (c == 0) ? 16 : (c == 1) ? 4 : (c == 2) ? 2 : 1;
    kvb_free_pool #(.DEPTH(NG*BPG), .GRP_BASE(GB), .BPG(BPG)) i_pool (
      .clk_i, .rst_ni,
      .pop_i(pool_pop[c]), .push_i(pool_push[c]), .push_ptr_i(push_ptr),
      .empty_o(pool_empty[c]), .head_o(pool_head[c])
    );
  end

  // smallest non-empty class at or above the wanted one
  logic [2:0] start_cls;
  logic [1:0] sel;
  logic       found, need_new, ins_ok, grow, hit;
  logic [DATA_W-1:0] hit_data;

  always_comb begin
    start_cls = cur.vld ? {1'b0, cur.cls} + 3'd1 : 3'd0;
    found     = 1'b0;
    sel       = 2'd0;
    for (int c = 3; c >= 0; c--) begin
      if (3'(c) >= start_cls && !pool_empty[c]) begin
        found = 1'b1;
        sel   = 2'(c);
      end
    end
  end

  assign need_new = !cur.vld || (cur_cnt >= cur_cap);
  assign ins_ok   = h_ins && !hit && (!need_new || found);
  assign grow     = h_vld && ins_ok && need_new;
  assign new_base = slot_of(pool_head[sel], sel);
  assign push_ptr = cur.ptr;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      pool_pop[c]  = grow && (sel == 2'(c));
      pool_push[c] = grow && cur.vld && (cur.cls == 2'(c));
    end
  end

  kvb_bucket_mem #(
    .SLOTS(SLOTS), .SLOT_AW(SLOT_AW), .KEY_W(KEY_W), .DATA_W(DATA_W), .BKT_MAX(16)
  ) i_mem (
    .clk_i,
    .cmp_base_i(cur_base), .cmp_cnt_i(cur_cnt), .cmp_key_i(h_key),
    .hit_o(hit), .hit_data_o(hit_data),
    .wr_en_i(h_vld && ins_ok), .mv_en_i(grow && cur.vld),
    .src_base_i(cur_base), .dst_base_i(need_new ? new_base : cur_base),
    .wr_pos_i(cur_cnt), .wr_key_i(h_key), .wr_data_i(h_data)
  );

  always_comb begin
    nxt_desc.vld = 1'b1;
    nxt_desc.cls = need_new ? sel : cur.cls;
    nxt_desc.ptr = need_new ? pool_head[sel] : cur.ptr;
    nxt_desc.cnt = cur_cnt + 5'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_N; i++) desc_q[i] <= '0;
    end else if (h_vld && ins_ok) begin
      desc_q[idx] <= nxt_desc;
    end
  end

  status_e st_d;
  always_comb begin
    if (!h_ins)      st_d = hit ? ST_OK : ST_MISS;
    else if (hit)    st_d = ST_DUP;
    else if (ins_ok) st_d = ST_OK;
    else             st_d = ST_FULL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= 2'd0;
      rsp_data_o   <= '0;
    end else begin
      if (accept)     busy_q <= 1'b1;
      else if (h_vld) busy_q <= 1'b0;
      rsp_valid_o  <= h_vld;
      rsp_status_o <= h_vld ? st_d : 2'd0;
      rsp_data_o   <= (h_vld && !h_ins && hit) ? hit_data : '0;
    end
  end
endmodule

// File: rtl/kvb_chk.sv
module kvb_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_status_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [3:0]        pool_pop_i,
  input logic [3:0]        pool_empty_i
);
  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o, 5)); // R3

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R3

  AST_READY_AT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o); // R3

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R3

  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 2'd0) |-> (rsp_data_o == '0)); // R5

  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pool_pop_i & pool_empty_i) == 4'd0); // R8

  AST_ONE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pool_pop_i)); // R7
endmodule

bind bucket_lookup kvb_chk #(.DATA_W(DATA_W)) i_kvb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o), .rsp_data_o(rsp_data_o),
  .pool_pop_i(pool_pop), .pool_empty_i(pool_empty)
);

// File: tb/test_bucket_lookup.sv
module test_bucket_lookup;
  localparam int TBL_MASK = 63;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         req_valid = 1'b0, req_insert = 1'b0;
  logic [127:0] req_key = '0, req_data = '0;
  logic         req_ready, rsp_valid;
  logic [1:0]   rsp_status;
  logic [127:0] rsp_data;

  bucket_lookup i_bucket_lookup (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_insert_i(req_insert), .req_key_i(req_key), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_data_o(rsp_data)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit m_vld [64];
  int m_cls [64];
  int m_cnt [64];
  int m_free [4];
  logic [127:0] kv [logic [127:0]];

  function automatic int cap(int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  function automatic int pick(int s);
    for (int c = s; c < 4; c++) if (m_free[c] > 0) return c;
    return -1;
  endfunction

  function automatic int tb_idx(logic [127:0] k);
    int unsigned s = 0;
    for (int w = 0; w < 8; w++) s += k[w*16 +: 16];
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return int'(s) & TBL_MASK;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] key_for(int idx);
    logic [127:0] k;
    do k = rnd128(); while (tb_idx(k) != idx || kv.exists(k));
    return k;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_cls[i] = 0; m_cnt[i] = 0; end
    m_free[0] = 16; m_free[1] = 4; m_free[2] = 2; m_free[3] = 1;
    kv.delete();
  endtask

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    model_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 128'(req_ready), 128'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 128'(rsp_valid), 128'd0);
  endtask

  task automatic model(bit ins, logic [127:0] k, logic [127:0] d,
                       output int es, output logic [127:0] ed);
    int i, c;
    i = tb_idx(k); ed = '0;
    if (!ins) begin
      if (kv.exists(k)) begin es = 0; ed = kv[k]; end else es = 1;
      return;
    end
    if (kv.exists(k)) begin es = 3; return; end
    if (!m_vld[i]) begin
      c = pick(0);
      if (c < 0) es = 2;
      else begin m_vld[i] = 1; m_cls[i] = c; m_cnt[i] = 1; m_free[c]--; es = 0; kv[k] = d; end
    end else if (m_cnt[i] < cap(m_cls[i])) begin
      m_cnt[i]++; es = 0; kv[k] = d;
    end else begin
      c = pick(m_cls[i] + 1);
      if (c < 0) es = 2;
      else begin
        m_free[c]--; m_free[m_cls[i]]++; m_cls[i] = c; m_cnt[i]++; es = 0; kv[k] = d;
      end
    end
  endtask

  task automatic dut_op(bit ins, logic [127:0] k, logic [127:0] d,
                        output int st, output logic [127:0] rd);
    int cyc;
    bit ready_low;
    @(negedge clk);
    req_valid = 1'b1; req_insert = ins; req_key = k; req_data = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; ready_low = 1'b1;
    while (!rsp_valid && cyc < 12) begin
      if (req_ready) ready_low = 1'b0;
      @(negedge clk);
      cyc++;
    end
    check(cyc == 5, "R3 latency", 128'(cyc), 128'd5);
    check(ready_low, "R3 ready low while busy", 128'(ready_low), 128'd1);
    st = int'(rsp_status); rd = rsp_data;
  endtask

  task automatic run(bit ins, logic [127:0] k, logic [127:0] d, string req);
    int es, st;
    logic [127:0] ed, rd;
    model(ins, k, d, es, ed);
    dut_op(ins, k, d, st, rd);
    check(st == es, {req, " status"}, 128'(st), 128'(es));
    check(rd == ed, {req, " data"}, rd, ed);
  endtask

  logic [127:0] ck [17];
  logic [127:0] pool_keys [48];

  initial begin
    void'($urandom(32'd20240611));
    model_reset();

    // R1 empty table after reset
    do_reset();
    run(1'b0, rnd128(), '0, "R1 search empty");

    // R6 R4 R10 R7 R9 on one index
    for (int i = 0; i < 17; i++) ck[i] = key_for(5);
    run(1'b1, ck[0], rnd128(), "R6 first insert");
    run(1'b0, ck[0], '0, "R4 search hit");
    run(1'b1, ck[0], rnd128(), "R10 duplicate insert");
    run(1'b0, ck[0], '0, "R10 data kept");
    for (int i = 1; i < 16; i++) begin
      run(1'b1, ck[i], rnd128(), "R7 promote insert");
      run(1'b0, ck[0], '0, "R7 old key kept");
    end
    for (int i = 0; i < 16; i++) run(1'b0, ck[i], '0, "R7 search after growth");
    run(1'b1, ck[16], rnd128(), "R9 overflow");
    run(1'b0, ck[16], '0, "R9 rejected key absent");
    run(1'b0, ck[0], '0, "R9 table unchanged");
    run(1'b0, ck[15], '0, "R5 miss/hit mix");
    run(1'b0, rnd128(), '0, "R5 miss");

    // R8 cascade across classes with distinct indices
    do_reset();
    for (int i = 0; i < 24; i++) run(1'b1, key_for(i), rnd128(), "R8 cascade insert");
    run(1'b1, key_for(40), rnd128(), "R8 all pools empty");

    // R11 released bucket reused
    do_reset();
    run(1'b1, key_for(0), rnd128(), "R11 insert");
    run(1'b1, key_for(0), rnd128(), "R11 promote");
    for (int i = 1; i < 30; i++) run(1'b1, key_for(i), rnd128(), "R11 refill");

    // R2 end-around carry: words 0x8000+0x8000 give index 1
    do_reset();
    run(1'b1, {96'd0, 16'h8000, 16'h8000}, 128'h1234, "R2 carry key");
    for (int i = 0; i < 16; i++) run(1'b1, key_for(1), rnd128(), "R2 shared index");
    run(1'b0, {96'd0, 16'h8000, 16'h8000}, '0, "R2 carry key search");

    // random mix
    do_reset();
    for (int i = 0; i < 48; i++) pool_keys[i] = key_for(8 + (i % 8) * 3);
    for (int n = 0; n < 400; n++) begin
      logic [127:0] k;
      int r;
      r = int'($urandom_range(0, 9));
      k = (r == 0) ? rnd128() : pool_keys[$urandom_range(0, 47)];
      if ($urandom_range(0, 1) == 1) run(1'b1, k, rnd128(), "R7 random insert");
      else                           run(1'b0, k, '0, "R4 random search");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule